// File: doc/BRIEF.md
# Weighted Fuzzy Rule Evaluator

This block walks a full two-input rule grid of a fuzzy controller. Input A carries `NA` membership degrees and input B carries `NB` degrees, each an 8-bit fraction of one. Every pairing of one degree from A with one from B is a rule. The premise strength of a rule is the fuzzy AND (minimum) of its two degrees. The fuzzy OR can be chosen instead, and it is built from the same minimum logic by complementing the operands and the result. The strength is scaled by the rule's stored 8-bit confidence. The weighted result goes into an output register file that a later aggregation stage reads.

With adaptation on, each rule's confidence is revised in the same pass. The firing strength, scaled by a reinforcement rate, is added. The old confidence, scaled by a decay rate, is removed. The result is clamped to the 8-bit range. Rules that fire hard gain weight and idle rules fade. In skip mode the block first lists the nonzero degrees on each side. It then visits only the rules where both degrees are nonzero and writes each result into its own slot. Slots it does not visit read zero.

A pass starts with a one-cycle `start` while the block is idle. `done` pulses when the pass is complete.

Top module: `fuzzy_rule_eval`

## Requirements
- R1: After reset every weighted-strength slot reads 0, every confidence reads `CONF_INIT` (128), and `busy` and `done` are low.
- R2: Rule r = i·NB + j pairs degree i of A (bits i·8+7..i·8 of `mu_a`) with degree j of B (bits j·8+7..j·8 of `mu_b`). With `or_mode`=0 its strength is f = min(a_i, b_j). Slot r of `wstr` (bits r·8+7..r·8) receives floor(f·v/256), where v is rule r's confidence at the start of the pass.
- R3: With `or_mode`=1 the strength is f = 255 − min(255 − a_i, 255 − b_j), which equals max(a_i, b_j).
- R4: With `adapt_en`=1, each visited rule's confidence becomes min(255, v + floor(rate_r·f/256) − floor(rate_d·v/256)), computed from the old v.
- R5: With `adapt_en`=0, every confidence is unchanged after the pass.
- R6: `done` is a one-cycle pulse on the K·P-th rising edge after the edge that accepts `start`. P is 7 with adaptation and 2 without. K is the number of rules visited, which is NA·NB outside skip mode. `busy` is high from the accepting edge until `done` rises.
- R7: With `skip_en`=1, only rules where both degrees are nonzero are visited, so K = (nonzero count in A)·(nonzero count in B). All slots are cleared at the accepting edge, so unvisited slots read 0. Confidences of unvisited rules are unchanged.
- R8: In skip mode, if either input has no nonzero degree, `done` rises on the accepting edge itself and `busy` stays low.
- R9: The degrees, rates and mode inputs are captured at the accepting edge. Changing them during a pass, or pulsing `start` while busy, has no effect on that pass.
- R10: Confidences carry over from pass to pass, so the next pass weights and adapts with the updated values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass when idle |
| adapt_en | input | 1 | Enable confidence learning |
| skip_en | input | 1 | Visit only rules with two nonzero degrees |
| or_mode | input | 1 | Premise uses fuzzy OR instead of AND |
| rate_r | input | 8 | Reinforcement rate, fraction of one |
| rate_d | input | 8 | Decay rate, fraction of one |
| mu_a | input | NA·8 | Membership degrees of input A |
| mu_b | input | NB·8 | Membership degrees of input B |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| wstr | output | NA·NB·8 | Weighted strengths, one byte per rule |
| conf | output | NA·NB·8 | Current rule confidences, one byte per rule |

## Verification
Both register files can be observed at the ports. A wrong confidence therefore shows up in `conf` as soon as the pass that produced it ends. It also shows up again in the next pass's weighted strengths, because a bad value feeds both later products. A fault in the grid counters or the nonzero-index lists puts results in the wrong slots, leaves nonzero bytes in slots that should be clear, or moves the `done` edge away from K·P. The bench compares every slot and the `done` timing after each pass, so such a fault is caught at the end of the pass that first uses the bad state.

// File: rtl/fuzzy_rule_eval.sv
module fuzzy_rule_eval #(
  parameter int NA = 5,
  parameter int NB = 4,
  parameter int DW = 8,
  parameter int CONF_INIT = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  adapt_en,
  input  logic                  skip_en,
  input  logic                  or_mode,
  input  logic [DW-1:0]         rate_r,
  input  logic [DW-1:0]         rate_d,
  input  logic [NA*DW-1:0]      mu_a,
  input  logic [NB*DW-1:0]      mu_b,
  output logic                  busy,
  output logic                  done,
  output logic [NA*NB*DW-1:0]   wstr,
  output logic [NA*NB*DW-1:0]   conf
);
  localparam int NR = NA * NB;
  localparam int AW = $clog2(NA + 1);
  localparam int BW = $clog2(NB + 1);
  localparam int RW = $clog2(NR);
  localparam logic [DW-1:0] MX = {DW{1'b1}};

  logic [DW-1:0] a_q [NA];
  logic [DW-1:0] b_q [NB];
  logic [DW-1:0] wf [NR];
  logic [DW-1:0] cf [NR];
  logic [AW-1:0] la_q [NA];
  logic [BW-1:0] lb_q [NB];
  logic [AW-1:0] la_c [NA];
  logic [BW-1:0] lb_c [NB];
  logic [AW-1:0] na_q, na_c, ia, sa, lim_a;
  logic [BW-1:0] nb_q, nb_c, ib, sb, lim_b;
  logic [DW-1:0] ra_q, rd_q, f_q, inc_q, dec_q, nv_q;
  logic signed [DW+1:0] s_q;
  logic adapt_q, skip_q, or_q;
  logic [2:0] ph, ph_last;

  always_comb begin
    na_c = '0;
    for (int i = 0; i < NA; i++) la_c[i] = '0;
    for (int i = 0; i < NA; i++)
      if (mu_a[i*DW +: DW] != '0) begin
        la_c[na_c] = AW'(i);
        na_c = na_c + 1'b1;
      end
  end

  always_comb begin
    nb_c = '0;
    for (int j = 0; j < NB; j++) lb_c[j] = '0;
    for (int j = 0; j < NB; j++)
      if (mu_b[j*DW +: DW] != '0) begin
        lb_c[nb_c] = BW'(j);
        nb_c = nb_c + 1'b1;
      end
  end

  assign sa    = skip_q ? la_q[ia] : ia;
  assign sb    = skip_q ? lb_q[ib] : ib;
  assign lim_a = skip_q ? na_q : AW'(NA);
  assign lim_b = skip_q ? nb_q : BW'(NB);

  logic [RW-1:0] ri;
  assign ri = RW'(sa * NB + sb);

  logic [DW-1:0] cur_v, op_a, op_b, mn, fval, newv;
  assign cur_v = skip_q ? cf[ri] : cf[0];
  assign op_a  = or_q ? ~a_q[sa] : a_q[sa];
  assign op_b  = or_q ? ~b_q[sb] : b_q[sb];
  assign mn    = (op_a < op_b) ? op_a : op_b;
  assign fval  = or_q ? ~mn : mn;
  assign newv  = adapt_q ? nv_q : cur_v;
  assign ph_last = adapt_q ? 3'd6 : 3'd1;

  logic [2*DW-1:0] p_w, p_inc, p_dec;
  assign p_w   = f_q * cur_v;
  assign p_inc = ra_q * f_q;
  assign p_dec = rd_q * cur_v;

  logic end_b, end_a;
  assign end_b = (ib + 1'b1) == lim_b;
  assign end_a = (ia + 1'b1) == lim_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      for (int k = 0; k < NR; k++) begin
        wf[k] <= '0;
        cf[k] <= DW'(CONF_INIT);
      end
      for (int i = 0; i < NA; i++) begin
        a_q[i]  <= '0;
        la_q[i] <= '0;
      end
      for (int j = 0; j < NB; j++) begin
        b_q[j]  <= '0;
        lb_q[j] <= '0;
      end
      na_q <= '0; nb_q <= '0; ia <= '0; ib <= '0; ph <= '0;
      ra_q <= '0; rd_q <= '0; f_q <= '0; inc_q <= '0; dec_q <= '0;
      nv_q <= '0; s_q <= '0;
      adapt_q <= 1'b0; skip_q <= 1'b0; or_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          for (int i = 0; i < NA; i++) begin
            a_q[i]  <= mu_a[i*DW +: DW];
            la_q[i] <= la_c[i];
          end
          for (int j = 0; j < NB; j++) begin
            b_q[j]  <= mu_b[j*DW +: DW];
            lb_q[j] <= lb_c[j];
          end
          na_q <= na_c; nb_q <= nb_c;
          ra_q <= rate_r; rd_q <= rate_d;
          adapt_q <= adapt_en; skip_q <= skip_en; or_q <= or_mode;
          ia <= '0; ib <= '0; ph <= '0;
          if (skip_en)
            for (int k = 0; k < NR; k++) wf[k] <= '0;
          if (skip_en && (na_c == '0 || nb_c == '0)) done <= 1'b1;
          else busy <= 1'b1;
        end
      end else begin
        ph <= ph + 3'd1;
        case (ph)
          3'd0: f_q <= fval;
          3'd1: begin
            if (skip_q) wf[ri] <= p_w[2*DW-1:DW];
            else begin
              for (int k = 0; k < NR - 1; k++) wf[k] <= wf[k+1];
              wf[NR-1] <= p_w[2*DW-1:DW];
            end
          end
          3'd2: inc_q <= p_inc[2*DW-1:DW];
          3'd3: dec_q <= p_dec[2*DW-1:DW];
          3'd4: s_q <= $signed({2'b00, cur_v}) + $signed({2'b00, inc_q})
                     - $signed({2'b00, dec_q});
          3'd5: nv_q <= s_q[DW+1] ? '0 : (s_q[DW] ? MX : s_q[DW-1:0]);
          default: ;
        endcase
        if (ph == ph_last) begin
          ph <= '0;
          if (skip_q) cf[ri] <= newv;
          else begin
            for (int k = 0; k < NR - 1; k++) cf[k] <= cf[k+1];
            cf[NR-1] <= newv;
          end
          if (end_b) begin
            ib <= '0;
            if (end_a) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else ia <= ia + 1'b1;
          end else ib <= ib + 1'b1;
        end
      end
    end
  end

  for (genvar k = 0; k < NR; k++) begin : g_out
    assign wstr[k*DW +: DW] = wf[k];
    assign conf[k*DW +: DW] = cf[k];
  end
endmodule

module fuzzy_rule_eval_chk #(
  parameter int NA = 5,
  parameter int NB = 4,
  parameter int DW = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                skip_en,
  input logic                busy,
  input logic                done,
  input logic [NA*NB*DW-1:0] wstr,
  input logic [NA*NB*DW-1:0] conf
);
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R6
  AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));  // R6
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy || done));  // R8
  AST_CONF_STILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(conf));  // R10
  AST_WSTR_STILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(start && skip_en)) |=> $stable(wstr));  // R9
  AST_SKIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && skip_en) |=> (wstr == '0));  // R7
endmodule

bind fuzzy_rule_eval fuzzy_rule_eval_chk #(.NA(NA), .NB(NB), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .skip_en(skip_en),
  .busy(busy), .done(done), .wstr(wstr), .conf(conf)
);

// File: tb/fuzzy_rule_eval_tb.sv
`timescale 1ns/1ps
module fuzzy_rule_eval_tb;
  localparam int NA = 5, NB = 4, NR = NA * NB;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic adapt_en = 1'b0, skip_en = 1'b0, or_mode = 1'b0;
  logic [7:0] rate_r = '0, rate_d = '0;
  logic [NA*8-1:0] mu_a = '0;
  logic [NB*8-1:0] mu_b = '0;
  logic busy, done;
  logic [NR*8-1:0] wstr, conf;

  int vectors = 0, errs = 0;
  int ma [NA];
  int mb [NB];
  int cm [NR];
  int ew [NR];

  always #5 clk = ~clk;

  fuzzy_rule_eval #(.NA(NA), .NB(NB), .DW(8), .CONF_INIT(128)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .adapt_en(adapt_en),
    .skip_en(skip_en), .or_mode(or_mode), .rate_r(rate_r), .rate_d(rate_d),
    .mu_a(mu_a), .mu_b(mu_b), .busy(busy), .done(done), .wstr(wstr), .conf(conf));

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int prem(input int a, input int b, input bit orm);
    int x, y, m;
    x = orm ? 255 - a : a;
    y = orm ? 255 - b : b;
    m = (x < y) ? x : y;
    return orm ? 255 - m : m;
  endfunction

  task automatic run_pass(input bit ad, input bit sk, input bit orm,
                          input int ra, input int rd, input bit scramble,
                          input string req);
    int k, n, p, f, nv;
    k = 0;
    for (int i = 0; i < NA; i++)
      for (int j = 0; j < NB; j++) begin
        int r;
        r = i * NB + j;
        if (!sk || (ma[i] != 0 && mb[j] != 0)) begin
          k++;
          f = prem(ma[i], mb[j], orm);
          ew[r] = (f * cm[r]) >> 8;
          if (ad) begin
            nv = cm[r] + ((ra * f) >> 8) - ((rd * cm[r]) >> 8);
            cm[r] = (nv > 255) ? 255 : nv;
          end
        end else if (sk) ew[r] = 0;
      end
    p = ad ? 7 : 2;
    @(negedge clk);
    for (int i = 0; i < NA; i++) mu_a[i*8 +: 8] = 8'(ma[i]);
    for (int j = 0; j < NB; j++) mu_b[j*8 +: 8] = 8'(mb[j]);
    adapt_en = ad; skip_en = sk; or_mode = orm;
    rate_r = 8'(ra); rate_d = 8'(rd);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (k > 0) chk("R6", "busy after accept", int'(busy), 1);
    else chk("R8", "busy on empty skip", int'(busy), 0);
    n = 0;
    while (!done && n < 20000) begin
      if (scramble) begin
        mu_a = {$urandom, $urandom};
        mu_b = $urandom;
        rate_r = 8'($urandom); rate_d = 8'($urandom);
        adapt_en = $urandom; skip_en = $urandom; or_mode = $urandom;
        start = 1'b1;
      end
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(k == 0 ? "R8" : "R6", "done edge count", n, k * p);
    @(posedge clk);
    @(negedge clk);
    chk("R6", "done width", int'(done), 0);
    for (int r = 0; r < NR; r++) begin
      chk(req, $sformatf("wstr[%0d]", r), int'(wstr[r*8 +: 8]), ew[r]);
      chk(req, $sformatf("conf[%0d]", r), int'(conf[r*8 +: 8]), cm[r]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2468));
    for (int r = 0; r < NR; r++) cm[r] = 128;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    for (int r = 0; r < NR; r++) begin
      chk("R1", "wstr reset", int'(wstr[r*8 +: 8]), 0);
      chk("R1", "conf reset", int'(conf[r*8 +: 8]), 128);
    end

    ma = '{10, 80, 255, 0, 140};
    mb = '{200, 35, 0, 255};
    run_pass(0, 0, 0, 0, 0, 0, "R2");
    run_pass(0, 0, 1, 77, 99, 0, "R3");
    run_pass(0, 0, 0, 255, 255, 0, "R5");

    ma = '{255, 255, 200, 255, 128};
    mb = '{255, 250, 255, 1};
    run_pass(1, 0, 0, 255, 0, 0, "R4");
    run_pass(1, 0, 0, 0, 255, 0, "R4");
    run_pass(1, 0, 1, 120, 40, 0, "R10");

    ma = '{0, 90, 0, 0, 255};
    mb = '{60, 0, 0, 180};
    run_pass(1, 1, 0, 200, 30, 0, "R7");
    run_pass(0, 1, 1, 0, 0, 0, "R7");

    ma = '{0, 0, 0, 0, 0};
    mb = '{9, 8, 7, 6};
    run_pass(1, 1, 0, 100, 100, 0, "R8");

    ma = '{33, 0, 190, 70, 255};
    mb = '{1, 128, 255, 0};
    run_pass(1, 0, 0, 150, 60, 1, "R9");
    run_pass(1, 1, 0, 90, 200, 1, "R9");

    for (int t = 0; t < 30; t++) begin
      for (int i = 0; i < NA; i++) ma[i] = ($urandom % 3 == 0) ? 0 : int'($urandom % 256);
      for (int j = 0; j < NB; j++) mb[j] = ($urandom % 3 == 0) ? 0 : int'($urandom % 256);
      run_pass($urandom % 2, $urandom % 2, $urandom % 2,
               int'($urandom % 256), int'($urandom % 256), $urandom % 2, "R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule